// File: doc/BRIEF.md
# Chained-Block Channel FIFO Manager

This block keeps the pointer bookkeeping for many channel FIFOs that all share one pool of fixed-size memory blocks. Software links blocks into circular chains by writing a next-block pointer RAM. It then gives each channel a chain by writing that channel's head block into a head-pointer RAM. The payload bytes live elsewhere. This block only tracks, for each channel, which block the producer is filling, which block the consumer is draining, and how many whole blocks lie filled between them.

A producer strobe on a channel closes the current write block and follows the chain to the next block. A consumer strobe releases the current read block in the same way. Each channel has a watermark word that holds a level and a direction. In drain mode the channel asks for service when enough blocks have filled. In fetch mode it asks for service when few enough blocks remain. Configuration goes through a 16-bit data register and per-RAM select registers. Writing a select register commits the data register into the addressed entry, or reads that entry back into the data register.

Top module: `llf_block_fifo_mgr`

## Requirements
- R1: After a synchronous active-low reset, svc_req is all zero, ovf_o and udf_o are 0, cfg_rdata is 0, and every channel's write and read block is 0.
- R2: cfg_addr 0 is the data register. cfg_addr 1 selects the next-block RAM (indexed by block), cfg_addr 2 selects the head RAM (indexed by channel) and cfg_addr 3 selects the watermark RAM (indexed by channel). A write to a select register with cfg_wdata bit 14 clear stores the data register into the entry whose index is cfg_wdata bits 9:0.
- R3: A select write with bit 14 set loads the addressed entry into the data register, which shows on cfg_rdata after that clock edge, and leaves the entry unchanged. A watermark word holds the level in bits 9:0 and the mode in bit 15 (0 = drain, 1 = fetch).
- R4: A head RAM commit sets that channel's write and read blocks to the committed block and empties the channel. Other channels are unaffected.
- R5: An accepted producer advance moves the channel's write block to the next-block entry of the current write block, including the wrap from the last chain block back to the first, and adds one filled block.
- R6: An accepted consumer advance moves the channel's read block to the next-block entry of the current read block and removes one filled block.
- R7: In drain mode, svc_req[ch] is 1 exactly when the level is non-zero and the filled count is at least the level.
- R8: In fetch mode, svc_req[ch] is 1 exactly when the filled count is at most the level.
- R9: A producer advance whose next block equals the channel's read block is refused, and ovf_o is 1 for the one cycle after that edge.
- R10: A consumer advance on a channel with no filled blocks is refused, and udf_o is 1 for the one cycle after that edge.
- R11: Producer and consumer advances on the same channel in one cycle are judged against the pointers from before that edge. Each advance that is accepted takes effect, and the count changes by the net amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 data, 1 next-block select, 2 head select, 3 watermark select |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Data register contents |
| prod_adv | input | 1 | Producer finished its current block |
| prod_ch | input | CH_W | Producer channel |
| prod_blk | output | 10 | Current write block of prod_ch |
| cons_adv | input | 1 | Consumer finished its current block |
| cons_ch | input | CH_W | Consumer channel |
| cons_blk | output | 10 | Current read block of cons_ch |
| svc_req | output | NUM_CH | Per-channel service request |
| ovf_o | output | 1 | Refused producer advance, one-cycle pulse |
| udf_o | output | 1 | Refused consumer advance, one-cycle pulse |

## Verification
The bench builds the block with 4 channels and 8 blocks. With that pool a three-block chain fills after two advances, so the overflow refusal, the wrap from the last block to the first, and the empty-channel underflow each come up within a handful of cycles. Two channels share one next-block RAM but run in opposite watermark modes, which shows that head commits and advances on one channel do not disturb the other.

// File: rtl/llf_pkg.sv
// Package llf_pkg
// Purpose : shared register codes and field positions for the chained-block
//           FIFO manager.
// Assumes : 16-bit configuration words; block pointers fit a 10-bit field.
package llf_pkg;
    typedef enum logic [1:0] {
        REG_DATA     = 2'd0,
        REG_NEXT_SEL = 2'd1,
        REG_HEAD_SEL = 2'd2,
        REG_MARK_SEL = 2'd3
    } cfg_reg_e;

    localparam int CFG_W       = 16;
    localparam int FIELD_W     = 10;
    localparam int RD_REQ_BIT  = 14;
    localparam int MODE_BIT    = 15;
endpackage

// File: rtl/llf_ram.sv
// Module llf_ram
// Purpose : register-array RAM with one synchronous write port and NRD
//           asynchronous read ports. It is cleared by reset.
// Assumes : DEPTH is a power of two, so every address is in range.
module llf_ram #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 8,
    parameter int NRD   = 1,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [AW-1:0]              waddr,
    input  logic [WIDTH-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]     raddr,
    output logic [NRD-1:0][WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Storage: clear on reset, otherwise write one entry on we.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read ports: each one is an independent combinational lookup.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end

    // R2: a committed word is present at its address after the edge.
    assert_ram_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/llf_cfg_port.sv
// Module llf_cfg_port
// Purpose : configuration register front end. It holds the data register,
//           decodes select-register writes into commit strobes, and loads
//           read-back words.
// Assumes : read words are presented combinationally for the index in
//           cfg_wdata during the cycle of the select write.
module llf_cfg_port
    import llf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic [CFG_W-1:0]   next_word,
    input  logic [CFG_W-1:0]   head_word,
    input  logic [CFG_W-1:0]   mark_word,
    output logic [CFG_W-1:0]   data_q,
    output logic [FIELD_W-1:0] idx,
    output logic               we_next,
    output logic               we_head,
    output logic               we_mark
);
    cfg_reg_e   reg_sel;
    logic       is_sel;
    logic       rd_req;
    logic [CFG_W-1:0] rd_word;

    // Decode: select writes become commits unless they request a read.
    always_comb begin
        reg_sel = cfg_reg_e'(cfg_addr);
        idx     = cfg_wdata[FIELD_W-1:0];
        rd_req  = cfg_wdata[RD_REQ_BIT];
        is_sel  = cfg_we && (reg_sel != REG_DATA);
        we_next = is_sel && !rd_req && (reg_sel == REG_NEXT_SEL);
        we_head = is_sel && !rd_req && (reg_sel == REG_HEAD_SEL);
        we_mark = is_sel && !rd_req && (reg_sel == REG_MARK_SEL);
        unique case (reg_sel)
            REG_NEXT_SEL: rd_word = next_word;
            REG_HEAD_SEL: rd_word = head_word;
            default:      rd_word = mark_word;
        endcase
    end

    // Data register: a direct write or a read-back load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (cfg_we && reg_sel == REG_DATA) begin
            data_q <= cfg_wdata;
        end else if (is_sel && rd_req) begin
            data_q <= rd_word;
        end
    end

    // R2: a data-register write is held for the commit that follows.
    assert_data_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 2'd0) |=> data_q == $past(cfg_wdata));
    // R3: a read request never produces a commit strobe.
    assert_read_no_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[RD_REQ_BIT]) |-> !(we_next || we_head || we_mark));
endmodule

// File: rtl/llf_chan_ctl.sv
// Module llf_chan_ctl
// Purpose : per-channel write/read block pointers, filled-block counters,
//           watermark words and service requests. It also flags refused
//           advances.
// Assumes : next-block lookups for the producer's write block and the
//           consumer's read block come in combinationally (nxt_w, nxt_r).
//           Head commits take priority over advances on the same channel.
module llf_chan_ctl #(
    parameter int NUM_CH  = 256,
    parameter int BLK_W   = 8,
    parameter int FIELD_W = 10,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prod_adv,
    input  logic [CH_W-1:0]    prod_ch,
    input  logic               cons_adv,
    input  logic [CH_W-1:0]    cons_ch,
    input  logic [BLK_W-1:0]   nxt_w,
    input  logic [BLK_W-1:0]   nxt_r,
    input  logic               head_we,
    input  logic [CH_W-1:0]    head_ch,
    input  logic [BLK_W-1:0]   head_val,
    input  logic               mark_we,
    input  logic [CH_W-1:0]    mark_ch,
    input  logic [FIELD_W-1:0] mark_lvl,
    input  logic               mark_mode,
    input  logic [CH_W-1:0]    mark_rd_ch,
    output logic [BLK_W-1:0]   wr_blk_sel,
    output logic [BLK_W-1:0]   rd_blk_sel,
    output logic [15:0]        mark_word,
    output logic [NUM_CH-1:0]  svc_req,
    output logic               ovf_q,
    output logic               udf_q
);
    logic [NUM_CH-1:0][BLK_W-1:0]   wr_all;
    logic [NUM_CH-1:0][BLK_W-1:0]   rd_all;
    logic [NUM_CH-1:0][FIELD_W-1:0] cnt_all;
    logic [NUM_CH-1:0][FIELD_W-1:0] lvl_all;
    logic [NUM_CH-1:0]              mode_all;
    logic blocked_p;
    logic empty_c;

    // Lookups for the channels addressed by the two ports and the config read.
    always_comb begin
        wr_blk_sel = wr_all[prod_ch];
        rd_blk_sel = rd_all[cons_ch];
        blocked_p  = (nxt_w == rd_all[prod_ch]);
        empty_c    = (cnt_all[cons_ch] == '0);
        mark_word  = {mode_all[mark_rd_ch], {(15-FIELD_W){1'b0}}, lvl_all[mark_rd_ch]};
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [BLK_W-1:0]   wr_q, rd_q;
        logic [FIELD_W-1:0] cnt_q, lvl_q;
        logic               mode_q;
        logic prod_hit, cons_hit, head_hit, acc_p, acc_c;

        // Acceptance of this channel's advances in this cycle.
        always_comb begin
            prod_hit = prod_adv && (prod_ch == CH_W'(i));
            cons_hit = cons_adv && (cons_ch == CH_W'(i));
            head_hit = head_we && (head_ch == CH_W'(i));
            acc_p    = prod_hit && !blocked_p;
            acc_c    = cons_hit && !empty_c;
        end

        // Pointer and count state: head commit reloads, advances follow the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wr_q  <= '0;
                rd_q  <= '0;
                cnt_q <= '0;
            end else if (head_hit) begin
                wr_q  <= head_val;
                rd_q  <= head_val;
                cnt_q <= '0;
            end else begin
                if (acc_p) wr_q <= nxt_w;
                if (acc_c) rd_q <= nxt_r;
                cnt_q <= cnt_q + FIELD_W'(acc_p) - FIELD_W'(acc_c);
            end
        end

        // Watermark word: level and direction.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q  <= '0;
                mode_q <= 1'b0;
            end else if (mark_we && mark_ch == CH_W'(i)) begin
                lvl_q  <= mark_lvl;
                mode_q <= mark_mode;
            end
        end

        // Service request: fetch mode compares low, drain mode compares high.
        always_comb begin
            if (mode_q) svc_req[i] = (cnt_q <= lvl_q);
            else        svc_req[i] = (lvl_q != '0) && (cnt_q >= lvl_q);
        end

        assign wr_all[i]   = wr_q;
        assign rd_all[i]   = rd_q;
        assign cnt_all[i]  = cnt_q;
        assign lvl_all[i]  = lvl_q;
        assign mode_all[i] = mode_q;

        // R9: a producer advance into the held read block leaves the write block.
        assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (prod_hit && blocked_p && !head_hit) |=> $stable(wr_q));
        // R10: a consumer advance on an empty channel leaves the read block.
        assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (cons_hit && cnt_q == '0 && !head_hit) |=> ($stable(rd_q) && cnt_q <= 1));
        // R4: a head commit leaves the channel empty with aligned pointers.
        assert_head_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
            head_hit |=> (wr_q == rd_q) && (cnt_q == '0));
    end

    // Refusal flags: registered one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            ovf_q <= prod_adv && blocked_p;
            udf_q <= cons_adv && empty_c;
        end
    end
endmodule

// File: rtl/llf_block_fifo_mgr.sv
// Module llf_block_fifo_mgr
// Purpose : top of the chained-block channel FIFO manager. It ties the
//           configuration front end, the next-block RAM, the head RAM and
//           the per-channel control together.
// Assumes : NUM_CH and NUM_BLK are powers of two, at least 2 and at most
//           1024. A select write whose index is out of range commits nothing.
module llf_block_fifo_mgr
    import llf_pkg::*;
#(
    parameter int NUM_CH   = 256,
    parameter int NUM_BLK  = 256,
    localparam int CH_W    = $clog2(NUM_CH),
    localparam int BLK_W   = $clog2(NUM_BLK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [15:0]        cfg_wdata,
    output logic [15:0]        cfg_rdata,
    input  logic               prod_adv,
    input  logic [CH_W-1:0]    prod_ch,
    output logic [9:0]         prod_blk,
    input  logic               cons_adv,
    input  logic [CH_W-1:0]    cons_ch,
    output logic [9:0]         cons_blk,
    output logic [NUM_CH-1:0]  svc_req,
    output logic               ovf_o,
    output logic               udf_o
);
    localparam logic [FIELD_W:0] CH_LIM  = (FIELD_W+1)'(NUM_CH);
    localparam logic [FIELD_W:0] BLK_LIM = (FIELD_W+1)'(NUM_BLK);

    logic [CFG_W-1:0]   data_q;
    logic [FIELD_W-1:0] idx;
    logic we_next_raw, we_head_raw, we_mark_raw;
    logic we_next, we_head, we_mark;
    logic [2:0][BLK_W-1:0] nx_raddr;
    logic [2:0][BLK_W-1:0] nx_rdata;
    logic [0:0][CH_W-1:0]  hd_raddr;
    logic [0:0][BLK_W-1:0] hd_rdata;
    logic [BLK_W-1:0] wr_sel, rd_sel;
    logic [15:0] mark_word;
    logic unused_bits;

    // Range gate: commits apply only to indices inside each RAM.
    always_comb begin
        we_next = we_next_raw && ({1'b0, idx} < BLK_LIM);
        we_head = we_head_raw && ({1'b0, idx} < CH_LIM);
        we_mark = we_mark_raw && ({1'b0, idx} < CH_LIM);
        nx_raddr[0] = idx[BLK_W-1:0];
        nx_raddr[1] = wr_sel;
        nx_raddr[2] = rd_sel;
        hd_raddr[0] = idx[CH_W-1:0];
    end

    assign unused_bits = ^{data_q, idx};

    llf_cfg_port u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .next_word (CFG_W'(nx_rdata[0])),
        .head_word (CFG_W'(hd_rdata[0])),
        .mark_word (mark_word),
        .data_q    (data_q),
        .idx       (idx),
        .we_next   (we_next_raw),
        .we_head   (we_head_raw),
        .we_mark   (we_mark_raw)
    );

    llf_ram #(.DEPTH(NUM_BLK), .WIDTH(BLK_W), .NRD(3)) u_next_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_next),
        .waddr (idx[BLK_W-1:0]),
        .wdata (data_q[BLK_W-1:0]),
        .raddr (nx_raddr),
        .rdata (nx_rdata)
    );

    llf_ram #(.DEPTH(NUM_CH), .WIDTH(BLK_W), .NRD(1)) u_head_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_head),
        .waddr (idx[CH_W-1:0]),
        .wdata (data_q[BLK_W-1:0]),
        .raddr (hd_raddr),
        .rdata (hd_rdata)
    );

    llf_chan_ctl #(.NUM_CH(NUM_CH), .BLK_W(BLK_W), .FIELD_W(FIELD_W)) u_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .prod_adv   (prod_adv),
        .prod_ch    (prod_ch),
        .cons_adv   (cons_adv),
        .cons_ch    (cons_ch),
        .nxt_w      (nx_rdata[1]),
        .nxt_r      (nx_rdata[2]),
        .head_we    (we_head),
        .head_ch    (idx[CH_W-1:0]),
        .head_val   (data_q[BLK_W-1:0]),
        .mark_we    (we_mark),
        .mark_ch    (idx[CH_W-1:0]),
        .mark_lvl   (data_q[FIELD_W-1:0]),
        .mark_mode  (data_q[MODE_BIT]),
        .mark_rd_ch (idx[CH_W-1:0]),
        .wr_blk_sel (wr_sel),
        .rd_blk_sel (rd_sel),
        .mark_word  (mark_word),
        .svc_req    (svc_req),
        .ovf_q      (ovf_o),
        .udf_q      (udf_o)
    );

    // Output widening of the selected block pointers.
    assign prod_blk  = FIELD_W'(wr_sel);
    assign cons_blk  = FIELD_W'(rd_sel);
    assign cfg_rdata = data_q;

    // R9: an overflow pulse always follows a producer strobe.
    assert_ovf_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> $past(prod_adv));
    // R10: an underflow pulse always follows a consumer strobe.
    assert_udf_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        udf_o |-> $past(cons_adv));
endmodule

// File: tb/llf_block_fifo_mgr_tb.sv
`timescale 1ns/1ps
module llf_block_fifo_mgr_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic       prod_adv = 1'b0;
    logic [1:0] prod_ch = '0;
    logic [9:0] prod_blk;
    logic       cons_adv = 1'b0;
    logic [1:0] cons_ch = '0;
    logic [9:0] cons_blk;
    logic [3:0] svc_req;
    logic       ovf_o, udf_o;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    llf_block_fifo_mgr #(.NUM_CH(4), .NUM_BLK(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .prod_adv(prod_adv),
        .prod_ch(prod_ch), .prod_blk(prod_blk), .cons_adv(cons_adv),
        .cons_ch(cons_ch), .cons_blk(cons_blk), .svc_req(svc_req),
        .ovf_o(ovf_o), .udf_o(udf_o)
    );

    // Table for channel 1, chain 4->5->6->4, drain level 2.
    // op[10:9] 1 prod 2 cons 3 both | wr[8:6] | rd[5:3] | req[2] | ovf[1] | udf[0]
    localparam logic [10:0] VEC [9] = '{
        {2'd2, 3'd4, 3'd4, 3'b001},
        {2'd1, 3'd5, 3'd4, 3'b000},
        {2'd1, 3'd6, 3'd4, 3'b100},
        {2'd1, 3'd6, 3'd4, 3'b110},
        {2'd3, 3'd6, 3'd5, 3'b010},  // R11: producer refused, consumer taken
        {2'd3, 3'd4, 3'd6, 3'b000},  // R11: both taken, count net unchanged
        {2'd2, 3'd4, 3'd4, 3'b000},
        {2'd2, 3'd4, 3'd4, 3'b001},
        {2'd1, 3'd5, 3'd4, 3'b000}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic commit(input logic [1:0] sel, input int index, input logic [15:0] d);
        reg_wr(2'd0, d);
        reg_wr(sel, 16'(index));
    endtask

    task automatic read_back(input logic [1:0] sel, input int index);
        reg_wr(sel, 16'h4000 | 16'(index));
    endtask

    task automatic step(input logic p, input logic c);
        prod_adv = p; cons_adv = c;
        @(negedge clk);
        prod_adv = 1'b0; cons_adv = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 svc_req", svc_req, 0);
        chk("R1 ovf_o", ovf_o, 0);
        chk("R1 udf_o", udf_o, 0);
        chk("R1 cfg_rdata", cfg_rdata, 0);
        chk("R1 prod_blk", prod_blk, 0);
        chk("R1 cons_blk", cons_blk, 0);

        // R2: build chain 4->5->6->4 in the next-block RAM
        commit(2'd1, 4, 16'd5);
        commit(2'd1, 5, 16'd6);
        commit(2'd1, 6, 16'd4);
        reg_wr(2'd0, 16'h00AA);
        chk("R2 data register", cfg_rdata, 16'h00AA);
        read_back(2'd1, 5);
        chk("R3 next[5] read", cfg_rdata, 6);
        read_back(2'd1, 5);
        chk("R3 next[5] unchanged by read", cfg_rdata, 6);
        commit(2'd2, 1, 16'd4);
        prod_ch = 2'd1; cons_ch = 2'd1;
        #1;
        chk("R4 ch1 write block after head", prod_blk, 4);
        chk("R4 ch1 read block after head", cons_blk, 4);
        read_back(2'd2, 1);
        chk("R3 head[1] read", cfg_rdata, 4);
        commit(2'd3, 1, 16'h0002);
        read_back(2'd3, 1);
        chk("R3 mark[1] read", cfg_rdata, 16'h0002);
        chk("R7 drain idle", svc_req[1], 0);

        // Table walk on channel 1
        for (int k = 0; k < 9; k++) begin
            step(VEC[k][9], VEC[k][10]);
            chk($sformatf("R5 step %0d write block", k), prod_blk, VEC[k][8:6]);
            chk($sformatf("R6 step %0d read block", k), cons_blk, VEC[k][5:3]);
            chk($sformatf("R7 step %0d request", k), svc_req[1], VEC[k][2]);
            chk($sformatf("R9 step %0d overflow", k), ovf_o, VEC[k][1]);
            chk($sformatf("R10 step %0d underflow", k), udf_o, VEC[k][0]);
        end

        // R8: channel 2 in fetch mode level 1 on chain 0->1->2->3->0
        commit(2'd1, 0, 16'd1);
        commit(2'd1, 1, 16'd2);
        commit(2'd1, 2, 16'd3);
        commit(2'd1, 3, 16'd0);
        commit(2'd2, 2, 16'd0);
        commit(2'd3, 2, 16'h8001);
        prod_ch = 2'd2; cons_ch = 2'd2;
        #1;
        chk("R8 fetch empty", svc_req[2], 1);
        step(1'b1, 1'b0);
        chk("R8 fetch one filled", svc_req[2], 1);
        step(1'b1, 1'b0);
        chk("R8 fetch two filled", svc_req[2], 0);
        chk("R5 ch2 write block", prod_blk, 2);
        step(1'b0, 1'b1);
        chk("R6 ch2 read block", cons_blk, 1);
        chk("R8 fetch after drain", svc_req[2], 1);
        prod_ch = 2'd1;
        #1;
        chk("R4 ch1 untouched by ch2", prod_blk, 5);
        chk("R7 ch1 untouched by ch2", svc_req[1], 0);

        // R4: re-head channel 2 at block 2, then wrap 3->0
        prod_ch = 2'd2;
        commit(2'd2, 2, 16'd2);
        chk("R4 ch2 write block reloaded", prod_blk, 2);
        chk("R4 ch2 read block reloaded", cons_blk, 2);
        chk("R4 ch2 emptied", svc_req[2], 1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        chk("R5 wrap to first block", prod_blk, 0);
        chk("R8 two filled after reload", svc_req[2], 0);
        chk("R9 no overflow on wrap", ovf_o, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule